// File: doc/BRIEF.md
# GPIO interrupt channel multiplexer

This block routes a wide vector of pad input signals onto a small, fixed set of interrupt lines. These lines feed a downstream interrupt controller that only understands active-high levels and rising edges. Each output channel picks one pad through its own select field. It can invert that pad, pass it through a programmable glitch filter, and then present it either as a level or as a one-clock pulse on a rising transition. With inversion, a falling-edge or active-low request becomes a rising-edge or active-high output, so the downstream controller never has to handle those senses itself.

Configuration lives in four 32-bit words behind a simple address / data / write-enable / read-enable port. One word holds the mode bits, two words hold the pad selectors and one word holds the filter lengths. Every pad goes through a two-flop synchronizer before selection. Detecting both edges on one channel is not supported: a channel sees either the rising or the falling edge of its pad, depending on its inversion bit.

Top module: `gpio_irq_router`

## Requirements
- R1: Reset clears all configuration, so every mapped word reads zero, and drives every `irq_out` bit low.
- R2: Register map, in byte offsets with `cfg_addr[1:0]` = 0:
  - 0x0 holds the mode word. Bit c enables edge mode for channel c, and bit 16+c inverts channel c. All other bits read zero.
  - 0x4 holds the pad selects of channels 0–3, and 0x8 holds those of channels 4–7. Each select is 8 bits wide at bit (c mod 4)*8.
  - 0xC holds a 4-bit filter length for channel c at bit c*4.
  - A read returns the whole word on `cfg_rdata` in the cycle after `cfg_re`. `cfg_rdata` is zero in every cycle that follows no read.
- R3: A write to an offset whose two low bits are not zero changes no register. A read of such an offset returns zero.
- R4: Each channel follows the synchronized pad chosen by its select field. With the filter at 0 or 1, a pad change applied between clock edges reaches `irq_out` at the fourth rising edge after it, and not earlier.
- R5: In level mode (mode bit c = 0), `irq_out[c]` is the filtered, possibly inverted pad level.
- R6: In edge mode, `irq_out[c]` is high for exactly one clock per rising transition of the filtered, possibly inverted signal. With inversion set, a falling pad produces the pulse.
- R7: With a filter length N of 2 or more, the filtered signal takes a new value only after the possibly inverted pad has held that value for N consecutive clocks. Shorter glitches are dropped. N = 0 and N = 1 behave alike, with no extra delay.
- R8: With the inversion bit set, a low pad produces a high `irq_out` in level mode, and a high pad produces a low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Asynchronous pad signals |
| cfg_addr | input | ADDR_W | Byte offset of the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CH | Active-high interrupt lines |

## Verification
The assertions assume that `cfg_re` and `cfg_we` are low while reset is held. They also assume that pad signals only matter after synchronization, so the filter check compares against the registered raw value and never against `pad_in` itself. The bench drives every input at the falling clock edge and holds reset with both strobes low. Its random phases reprogram all four words and then toggle only whole-cycle pad levels, which keeps the stimulus inside those assumptions while still landing glitches shorter than the programmed filter lengths.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned INV_BASE = 16;
  localparam int unsigned MODE_WORD = 0;

  function automatic int unsigned sel_per_word(input int unsigned sel_w);
    return CFG_W / sel_w;
  endfunction
endpackage

// File: rtl/gpio_irq_pad_sync.sv
module gpio_irq_pad_sync #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_cfg_regs.sv
module gpio_irq_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned FLT_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [CFG_W-1:0]        wdata,
  input  logic                    we,
  input  logic                    re,
  output logic [CFG_W-1:0]        rdata,
  output logic [NUM_CH-1:0]       edge_en,
  output logic [NUM_CH-1:0]       invert,
  output logic [NUM_CH*SEL_W-1:0] sel_flat,
  output logic [NUM_CH*FLT_W-1:0] flt_flat
);
  localparam int unsigned SPW       = sel_per_word(SEL_W);
  localparam int unsigned SEL_WORDS = (NUM_CH + SPW - 1) / SPW;
  localparam int unsigned FLT_WORD  = SEL_WORDS + 1;
  localparam int unsigned WORD_W    = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic [CFG_W-1:0]  rd_val;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_en  <= '0;
      invert   <= '0;
      sel_flat <= '0;
      flt_flat <= '0;
    end else if (we && aligned) begin
      if (int'(word) == MODE_WORD) begin
        edge_en <= wdata[NUM_CH-1:0];
        invert  <= wdata[INV_BASE +: NUM_CH];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(word) == 1 + c / SPW)
          sel_flat[c*SEL_W +: SEL_W] <= wdata[(c % SPW)*SEL_W +: SEL_W];
      end
      if (int'(word) == FLT_WORD)
        flt_flat <= wdata[NUM_CH*FLT_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (int'(word) == MODE_WORD) begin
        rd_val[NUM_CH-1:0]          = edge_en;
        rd_val[INV_BASE +: NUM_CH]  = invert;
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(word) == 1 + c / SPW)
          rd_val[(c % SPW)*SEL_W +: SEL_W] = sel_flat[c*SEL_W +: SEL_W];
      end
      if (int'(word) == FLT_WORD)
        rd_val[NUM_CH*FLT_W-1:0] = flt_flat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= re ? rd_val : '0;
  end
endmodule

// File: rtl/gpio_irq_glitch_filter.sv
module gpio_irq_glitch_filter #(
  parameter int unsigned FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  logic [FLT_W-1:0] len,
  output logic             filt_q
);
  logic [FLT_W-1:0] run_cnt;
  logic [FLT_W:0]   run_next;

  assign run_next = {1'b0, run_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      filt_q  <= 1'b0;
    end else if (raw == filt_q) begin
      run_cnt <= '0;
    end else if (run_next >= {1'b0, len}) begin
      filt_q  <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_next[FLT_W-1:0];
    end
  end
endmodule

// File: rtl/gpio_irq_channel.sv
module gpio_irq_channel #(
  parameter int unsigned FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pad_bit,
  input  logic             invert,
  input  logic             edge_en,
  input  logic [FLT_W-1:0] flt_len,
  output logic             irq_q,
  output logic             raw_o,
  output logic             filt_o
);
  logic filt_d;

  assign raw_o = pad_bit ^ invert;

  gpio_irq_glitch_filter #(.FLT_W(FLT_W)) u_filter (
    .clk    (clk),
    .rst    (rst),
    .raw    (raw_o),
    .len    (flt_len),
    .filt_q (filt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_d <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      filt_d <= filt_o;
      irq_q  <= edge_en ? (filt_o & ~filt_d) : filt_o;
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned NUM_PADS = 256,
  parameter int unsigned SEL_W    = 8,
  parameter int unsigned FLT_W    = 4,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic                cfg_we,
  input  logic                cfg_re,
  output logic [31:0]         cfg_rdata,
  output logic [NUM_CH-1:0]   irq_out
);
  logic [NUM_PADS-1:0]     pad_sync;
  logic [NUM_CH-1:0]       ch_edge;
  logic [NUM_CH-1:0]       ch_inv;
  logic [NUM_CH*SEL_W-1:0] ch_sel;
  logic [NUM_CH*FLT_W-1:0] ch_flt;
  logic [NUM_CH-1:0]       ch_raw;
  logic [NUM_CH-1:0]       ch_filt;

  gpio_irq_pad_sync #(.W(NUM_PADS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_irq_cfg_regs #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .FLT_W  (FLT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .we       (cfg_we),
    .re       (cfg_re),
    .rdata    (cfg_rdata),
    .edge_en  (ch_edge),
    .invert   (ch_inv),
    .sel_flat (ch_sel),
    .flt_flat (ch_flt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEL_W-1:0] sel;
    logic             pick;

    assign sel = ch_sel[c*SEL_W +: SEL_W];

    always_comb begin
      pick = 1'b0;
      for (int p = 0; p < NUM_PADS; p++)
        if (int'(sel) == p) pick = pad_sync[p];
    end

    gpio_irq_channel #(.FLT_W(FLT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .pad_bit (pick),
      .invert  (ch_inv[c]),
      .edge_en (ch_edge[c]),
      .flt_len (ch_flt[c*FLT_W +: FLT_W]),
      .irq_q   (irq_out[c]),
      .raw_o   (ch_raw[c]),
      .filt_o  (ch_filt[c])
    );
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_re,
  input logic [31:0]       cfg_rdata,
  input logic [NUM_CH-1:0] irq_out,
  input logic [NUM_CH-1:0] ch_edge,
  input logic [NUM_CH-1:0] ch_raw,
  input logic [NUM_CH-1:0] ch_filt
);
  localparam logic [31:0] CH_BITS   = (32'd1 << NUM_CH) - 32'd1;
  localparam logic [31:0] MODE_MASK = CH_BITS | (CH_BITS << 16);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> irq_out == '0); // R1

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_re) |-> cfg_rdata == '0); // R2

  AST_RD_MODE_UNUSED: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_re) && $past(cfg_addr) == '0) |-> (cfg_rdata & ~MODE_MASK) == '0); // R2

  AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_re) && $past(cfg_addr[1:0]) != 2'b00) |-> cfg_rdata == '0); // R3

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (irq_out & $past(irq_out) & $past(ch_edge)) == '0); // R6

  AST_FILTER_FROM_RAW: assert property (@(posedge clk) disable iff (rst)
    ((ch_filt ^ $past(ch_filt)) & (ch_filt ^ $past(ch_raw))) == '0); // R7
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_addr  (cfg_addr),
  .cfg_re    (cfg_re),
  .cfg_rdata (cfg_rdata),
  .irq_out   (irq_out),
  .ch_edge   (ch_edge),
  .ch_raw    (ch_raw),
  .ch_filt   (ch_filt)
);

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  localparam int NUM_CH = 8, NUM_PADS = 256, SEL_W = 8, FLT_W = 4, ADDR_W = 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NUM_PADS-1:0] pad_in = '0;
  logic [ADDR_W-1:0]   cfg_addr = '0;
  logic [31:0]         cfg_wdata = '0;
  logic                cfg_we = 1'b0;
  logic                cfg_re = 1'b0;
  logic [31:0]         cfg_rdata;
  logic [NUM_CH-1:0]   irq_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench-side expectation state
  logic [NUM_PADS-1:0] m_s1, m_s2;
  logic [NUM_CH-1:0]   m_edge, m_inv, m_filt, m_filtd, m_out;
  int                  m_sel [NUM_CH];
  int                  m_flt [NUM_CH];
  int                  m_cnt [NUM_CH];

  always #5 clk = ~clk;

  gpio_irq_router #(
    .NUM_CH(NUM_CH), .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .FLT_W(FLT_W), .ADDR_W(ADDR_W)
  ) u_gpio_irq_router (
    .clk(clk), .rst(rst), .pad_in(pad_in), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int c);
    if (m_flt[c] > 1) return "R7";
    if (m_edge[c])    return "R6";
    if (m_inv[c])     return "R8";
    return "R5";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_edge = '0; m_inv = '0;
      m_filt = '0; m_filtd = '0; m_out = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        m_sel[c] = 0; m_flt[c] = 0; m_cnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        logic raw;
        raw = m_s2[m_sel[c]] ^ m_inv[c];
        m_out[c]   = m_edge[c] ? (m_filt[c] & ~m_filtd[c]) : m_filt[c];
        m_filtd[c] = m_filt[c];
        if (raw == m_filt[c]) m_cnt[c] = 0;
        else if (m_cnt[c] + 1 >= m_flt[c]) begin
          m_filt[c] = raw;
          m_cnt[c]  = 0;
        end else m_cnt[c] = m_cnt[c] + 1;
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (cfg_we && cfg_addr[1:0] == 2'b00) begin
        case (cfg_addr[3:2])
          2'd0: begin m_edge = cfg_wdata[7:0]; m_inv = cfg_wdata[23:16]; end
          2'd1: for (int c = 0; c < 4; c++) m_sel[c] = int'(cfg_wdata[c*8 +: 8]);
          2'd2: for (int c = 4; c < 8; c++) m_sel[c] = int'(cfg_wdata[(c-4)*8 +: 8]);
          default: for (int c = 0; c < NUM_CH; c++) m_flt[c] = int'(cfg_wdata[c*4 +: 4]);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished)
      for (int c = 0; c < NUM_CH; c++)
        check(irq_out[c] === m_out[c], tag_of(c), 32'(irq_out[c]), 32'(m_out[c]));
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_re = 1'b1;
    @(negedge clk);
    d = cfg_rdata;
    cfg_re = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(irq_out == '0, "R1 irq after reset", 32'(irq_out), 0);
    rst = 1'b0;
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), d);
      check(d == 0, "R1 reg after reset", d, 0);
    end

    // R2 readback with field masking
    for (int a = 0; a < 16; a += 4) begin
      v = $urandom;
      wr(4'(a), v);
      rd(4'(a), d);
      check(d == ((a == 0) ? (v & 32'h00FF00FF) : v), "R2 readback", d, (a == 0) ? (v & 32'h00FF00FF) : v);
    end

    // R3 misaligned accesses
    for (int a = 0; a < 16; a += 4) wr(4'(a), 32'h0);
    wr(4'h1, 32'hFFFFFFFF);
    wr(4'h6, 32'hFFFFFFFF);
    wr(4'hF, 32'hFFFFFFFF);
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), d);
      check(d == 0, "R3 ignored write", d, 0);
    end
    wr(4'h0, 32'h00FF00FF);
    rd(4'h2, d);
    check(d == 0, "R3 unmapped read", d, 0);
    wr(4'h0, 32'h0);

    // R4 routing and latency: ch3 selects pad 200
    wr(4'h4, 32'(200) << 24);
    wait_n(6);
    pad_in[200] = 1'b1;
    wait_n(3);
    check(irq_out == 8'h00, "R4 not before 4th edge", 32'(irq_out), 0);
    wait_n(1);
    check(irq_out == 8'h08, "R4 routed pad", 32'(irq_out), 32'h08);

    // R8 inversion in level mode
    wr(4'h0, 32'h00080000);
    wait_n(6);
    check(irq_out[3] == 1'b0, "R8 high pad inverted", 32'(irq_out[3]), 0);
    pad_in[200] = 1'b0;
    wait_n(5);
    check(irq_out[3] == 1'b1, "R8 low pad inverted", 32'(irq_out[3]), 1);

    // R6 edge mode, rising then falling with inversion
    wr(4'h0, 32'h00000008);
    wait_n(6);
    pad_in[200] = 1'b1;
    wait_n(4);
    check(irq_out[3] == 1'b1, "R6 rising pulse", 32'(irq_out[3]), 1);
    wait_n(1);
    check(irq_out[3] == 1'b0, "R6 pulse one cycle", 32'(irq_out[3]), 0);
    wr(4'h0, 32'h00080008);
    wait_n(8);
    pad_in[200] = 1'b0;
    wait_n(4);
    check(irq_out[3] == 1'b1, "R6 falling pulse", 32'(irq_out[3]), 1);
    wait_n(1);
    check(irq_out[3] == 1'b0, "R6 falling pulse one cycle", 32'(irq_out[3]), 0);

    // R7 filter length 3 on ch3, level mode
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h00003000);
    wait_n(8);
    pad_in[200] = 1'b1;
    wait_n(2);
    pad_in[200] = 1'b0;
    wait_n(10);
    check(irq_out[3] == 1'b0, "R7 glitch dropped", 32'(irq_out[3]), 0);
    pad_in[200] = 1'b1;
    wait_n(5);
    check(irq_out[3] == 1'b0, "R7 not yet settled", 32'(irq_out[3]), 0);
    wait_n(1);
    check(irq_out[3] == 1'b1, "R7 settled after N", 32'(irq_out[3]), 1);

    // random phases checked by the expectation model (R5 R6 R7 R8)
    for (int ph = 0; ph < 40; ph++) begin
      wr(4'h0, $urandom & 32'h00FF00FF);
      wr(4'h4, $urandom);
      wr(4'h8, $urandom);
      wr(4'hC, $urandom);
      repeat (300) begin
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++)
          if ($urandom_range(7) == 0) pad_in[m_sel[c]] = ~pad_in[m_sel[c]];
        if ($urandom_range(15) == 0) begin
          int p;
          p = int'($urandom_range(NUM_PADS - 1));
          pad_in[p] = ~pad_in[p];
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule